// File: doc/BRIEF.md
# Masked Majority Trigger Logic

This block turns a vector of per-channel self-trigger bits into one board-level trigger. The channels first pass through an enable mask. Neighbouring channels 2k and 2k+1 can then be merged into a coincidence (AND) or a union (OR). When they are merged, both positions of the pair carry the merged value. The main stage reduces the resulting vector in one of three ways: any bit set, every enabled position set, or a count of set bits compared against a programmed level.

The decision can go straight to the output. It can also be reshaped by a gate generator of programmable width, in either a retriggerable or a non-retriggerable form. A polarity control then passes the shaped signal through unchanged or inverts it. The count is split over two register stages so that wide vectors close timing. Every main mode goes through the same stages, so all modes show the same latency.

Top module: `trig_majority_unit`

## Requirements
- R1: A channel whose `cfg_mask` bit is 0 is ignored: its `trig_in` bit acts as 0 in every later stage.
- R2: Pair code 0 or 3 (`cfg_pair`) passes the masked bits through unchanged.
- R3: Pair code 1 sets both positions 2k and 2k+1 to the OR of the two masked bits. In majority mode such a merged pair is counted twice.
- R4: Pair code 2 sets both positions 2k and 2k+1 to the AND of the two masked bits.
- R5: Main code 0 (`cfg_main`) raises the decision when any pair-stage output bit is 1.
- R6: Main code 1 raises the decision when every pair-stage output at a position whose mask bit is 1 equals 1. With an all-zero mask the decision is 0.
- R7: Main code 2 or 3 raises the decision when the number of 1 bits in the pair-stage output is at least `cfg_maj_lvl`. A level of 0 is always met.
- R8: With `cfg_gate_w` equal to 0 (linear mode), the input present at rising edge k sets `trig_out` just after rising edge k+2. The output holds that value for exactly one cycle per decision.
- R9: With `cfg_gate_w` = W > 0 and `cfg_retrig` = 0, a decision arriving while the gate is closed opens it for exactly W cycles. Decisions that arrive while the gate is open neither lengthen it nor restart it.
- R10: With `cfg_gate_w` = W > 0 and `cfg_retrig` = 1, the gate stays open until W cycles after the most recent decision.
- R11: `cfg_invert` = 1 inverts the output. While reset is held, the pipeline and the gate are cleared, so `trig_out` equals `cfg_invert`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | N_CH | Per-channel self-trigger bits |
| cfg_mask | input | N_CH | Channel enable, 1 = channel takes part |
| cfg_pair | input | 2 | Pair stage: 0/3 pass, 1 OR, 2 AND |
| cfg_main | input | 2 | Main stage: 0 OR, 1 AND, 2/3 majority |
| cfg_maj_lvl | input | $clog2(N_CH+1) | Majority threshold |
| cfg_gate_w | input | GATE_W | Gate width in cycles, 0 = linear |
| cfg_retrig | input | 1 | 1 = gate is retriggerable |
| cfg_invert | input | 1 | 1 = invert the output |
| trig_out | output | 1 | Shaped board trigger |

## Verification
The assertions check on every cycle that the gate only opens on a decision and that linear mode copies the decision one cycle later. They also check that a retriggerable gate is open after each decision, that a non-retriggerable gate never stays open longer than its width, and that an all-zero mask keeps the OR and AND decisions low. Only the bench scenarios can confirm the combinational function itself: sweeps over every input vector for each pair mode, main mode, mask and level. The exact gate lengths under sparse random decisions with inversion come from those scenarios too, and they are compared against an arithmetic model.

// File: rtl/trig_majority_pkg.sv
// Shared encodings for the masked majority trigger unit.
package trig_majority_pkg;

    typedef enum logic [1:0] {
        PAIR_PASS  = 2'd0,
        PAIR_OR    = 2'd1,
        PAIR_AND   = 2'd2,
        PAIR_PASS2 = 2'd3
    } pair_mode_e;

    typedef enum logic [1:0] {
        MAIN_OR   = 2'd0,
        MAIN_AND  = 2'd1,
        MAIN_MAJ  = 2'd2,
        MAIN_MAJ2 = 2'd3
    } main_mode_e;

endpackage

// File: rtl/trig_pair_stage.sv
// Masks the channel bits and optionally merges each even/odd pair.
// Assumes N_CH is even. Purely combinational.
module trig_pair_stage
    import trig_majority_pkg::*;
#(
    parameter int N_CH = 64
) (
    input  logic [N_CH-1:0] trig_in,
    input  logic [N_CH-1:0] mask,
    input  pair_mode_e      mode,
    output logic [N_CH-1:0] pair_out
);
    localparam int N_PAIR = N_CH / 2;

    for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
        logic lo_bit;
        logic hi_bit;
        assign lo_bit = trig_in[2*k]   & mask[2*k];
        assign hi_bit = trig_in[2*k+1] & mask[2*k+1];

        // Select merged or pass-through value for both pair positions.
        always_comb begin
            case (mode)
                PAIR_OR:  pair_out[2*k+1 -: 2] = {2{lo_bit | hi_bit}};
                PAIR_AND: pair_out[2*k+1 -: 2] = {2{lo_bit & hi_bit}};
                default:  pair_out[2*k+1 -: 2] = {hi_bit, lo_bit};
            endcase
        end
    end
endmodule

// File: rtl/trig_reduce_stage.sv
// Two-stage reduction of the pair-stage vector: stage one registers
// per-group bit counts plus the OR and masked AND; stage two sums the
// groups and picks the main-mode decision. Assumes GRP divides N_CH.
module trig_reduce_stage
    import trig_majority_pkg::*;
#(
    parameter int N_CH = 64,
    parameter int GRP  = 8,
    parameter int CNT_W = $clog2(N_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  pair_vec,
    input  logic [N_CH-1:0]  mask,
    input  main_mode_e       main_mode,
    input  logic [CNT_W-1:0] maj_lvl,
    output logic             hit_q
);
    localparam int NGRP = N_CH / GRP;
    localparam int PS_W = $clog2(GRP + 1);

    logic [PS_W-1:0]  grp_sum [NGRP];
    logic [PS_W-1:0]  grp_sum_q [NGRP];
    logic             any_q;
    logic             all_q;
    logic             all_comb;
    logic [CNT_W-1:0] total;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // Count the set bits of one group.
        always_comb begin
            grp_sum[g] = '0;
            for (int i = 0; i < GRP; i++) begin
                grp_sum[g] = grp_sum[g] + PS_W'(pair_vec[g*GRP + i]);
            end
        end
    end

    // Masked AND: enabled positions must all be set, empty mask gives 0.
    assign all_comb = (|mask) && (&(pair_vec | ~mask));

    // Stage one registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q <= 1'b0;
            all_q <= 1'b0;
            for (int g = 0; g < NGRP; g++) grp_sum_q[g] <= '0;
        end else begin
            any_q <= |pair_vec;
            all_q <= all_comb;
            for (int g = 0; g < NGRP; g++) grp_sum_q[g] <= grp_sum[g];
        end
    end

    // Sum the registered group counts.
    always_comb begin
        total = '0;
        for (int g = 0; g < NGRP; g++) begin
            total = total + CNT_W'(grp_sum_q[g]);
        end
    end

    // Stage two: main-mode decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            case (main_mode)
                MAIN_OR:  hit_q <= any_q;
                MAIN_AND: hit_q <= all_q;
                default:  hit_q <= (total >= maj_lvl);
            endcase
        end
    end
endmodule

// File: rtl/trig_gate_shaper.sv
// Output gate generator. Width 0 copies the decision; otherwise the gate
// opens for width cycles, restarting on each decision when retriggerable,
// or only from the closed state when not.
module trig_gate_shaper #(
    parameter int GATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [GATE_W-1:0] width,
    input  logic              retrig,
    output logic              gate_q
);
    logic [GATE_W-1:0] remain_q;
    logic              linear;
    logic              start;

    assign linear = (width == '0);
    assign start  = hit && (retrig || !gate_q);

    // Gate state and remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q   <= 1'b0;
            remain_q <= '0;
        end else if (linear) begin
            gate_q   <= hit;
            remain_q <= '0;
        end else if (start) begin
            gate_q   <= 1'b1;
            remain_q <= width - GATE_W'(1);
        end else if (remain_q != '0) begin
            gate_q   <= 1'b1;
            remain_q <= remain_q - GATE_W'(1);
        end else begin
            gate_q   <= 1'b0;
        end
    end
endmodule

// File: rtl/trig_majority_unit.sv
// Board-level trigger combiner: mask, pair merge, OR/AND/majority
// reduction, gate shaping and polarity. Latency of the decision is two
// cycles, plus one cycle for the gate register.
module trig_majority_unit
    import trig_majority_pkg::*;
#(
    parameter int N_CH   = 64,
    parameter int GRP    = 8,
    parameter int GATE_W = 16,
    localparam int CNT_W = $clog2(N_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   trig_in,
    input  logic [N_CH-1:0]   cfg_mask,
    input  logic [1:0]        cfg_pair,
    input  logic [1:0]        cfg_main,
    input  logic [CNT_W-1:0]  cfg_maj_lvl,
    input  logic [GATE_W-1:0] cfg_gate_w,
    input  logic              cfg_retrig,
    input  logic              cfg_invert,
    output logic              trig_out
);
    logic [N_CH-1:0] pair_vec;
    logic            hit_q;
    logic            gate_q;

    trig_pair_stage #(.N_CH(N_CH)) u_pair (
        .trig_in  (trig_in),
        .mask     (cfg_mask),
        .mode     (pair_mode_e'(cfg_pair)),
        .pair_out (pair_vec)
    );

    trig_reduce_stage #(.N_CH(N_CH), .GRP(GRP), .CNT_W(CNT_W)) u_reduce (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_vec  (pair_vec),
        .mask      (cfg_mask),
        .main_mode (main_mode_e'(cfg_main)),
        .maj_lvl   (cfg_maj_lvl),
        .hit_q     (hit_q)
    );

    trig_gate_shaper #(.GATE_W(GATE_W)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit_q),
        .width  (cfg_gate_w),
        .retrig (cfg_retrig),
        .gate_q (gate_q)
    );

    assign trig_out = gate_q ^ cfg_invert;
endmodule

// File: rtl/trig_majority_unit_chk.sv
// Temporal checks on the trigger unit, bound onto every instance.
module trig_majority_unit_chk #(
    parameter int N_CH   = 64,
    parameter int GATE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_CH-1:0]   cfg_mask,
    input logic [1:0]        cfg_main,
    input logic [GATE_W-1:0] cfg_gate_w,
    input logic              cfg_retrig,
    input logic              hit_q,
    input logic              gate_q
);
    logic [31:0] run_q;

    // Count consecutive cycles the gate has been open.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= gate_q ? run_q + 32'd1 : 32'd0;
    end

    // R1 R5 R6: an all-zero mask keeps OR and AND decisions low.
    p_masked_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mask, 2) == '0 && $past(cfg_main) <= 2'd1) |-> !hit_q);

    // R8: linear mode copies the decision one cycle later.
    p_linear_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_gate_w) == '0) |-> (gate_q == $past(hit_q)));

    // R9: non-retriggerable gate never exceeds its width.
    p_gate_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && !cfg_retrig && cfg_gate_w != '0 && $stable(cfg_gate_w)
         && $stable(cfg_retrig)) |-> (run_q < 32'(cfg_gate_w)));

    // R10: a decision always leaves a retriggerable gate open.
    p_retrig_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && cfg_retrig && cfg_gate_w != '0) |=> gate_q);

    // R9 R10: the gate opens only because of a decision.
    p_open_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> $past(hit_q));
endmodule

bind trig_majority_unit trig_majority_unit_chk #(
    .N_CH(N_CH), .GATE_W(GATE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_main(cfg_main),
    .cfg_gate_w(cfg_gate_w), .cfg_retrig(cfg_retrig),
    .hit_q(hit_q), .gate_q(gate_q)
);

// File: tb/trig_majority_unit_tb.sv
// Sweeps every 8-bit input for each pair/main/mask/level setting in linear
// mode, then drives sparse random decisions through each gate setting.
module trig_majority_unit_tb;
    localparam int NC = 8;
    localparam int GW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] trig_in = '0;
    logic [NC-1:0] cfg_mask = '1;
    logic [1:0]    cfg_pair = 2'd0;
    logic [1:0]    cfg_main = 2'd0;
    logic [3:0]    cfg_maj_lvl = 4'd0;
    logic [GW-1:0] cfg_gate_w = '0;
    logic          cfg_retrig = 1'b0;
    logic          cfg_invert = 1'b1;
    logic          trig_out;

    int vectors = 0;
    int fails = 0;
    int edge_n = 0;
    int close_e = -100;
    bit hm1 = 1'b0;
    bit hm2 = 1'b0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    trig_majority_unit #(.N_CH(NC), .GRP(4), .GATE_W(GW)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_mask(cfg_mask),
        .cfg_pair(cfg_pair), .cfg_main(cfg_main), .cfg_maj_lvl(cfg_maj_lvl),
        .cfg_gate_w(cfg_gate_w), .cfg_retrig(cfg_retrig),
        .cfg_invert(cfg_invert), .trig_out(trig_out)
    );

    // Expected decision from the requirement text (R1..R7).
    function automatic bit ref_hit(logic [7:0] v);
        logic [7:0] m;
        logic [7:0] p;
        int n;
        m = v & cfg_mask;
        p = m;
        for (int k = 0; k < 4; k++) begin
            if (cfg_pair == 2'd1) p[2*k+:2] = {2{m[2*k] | m[2*k+1]}};
            else if (cfg_pair == 2'd2) p[2*k+:2] = {2{m[2*k] & m[2*k+1]}};
        end
        n = 0;
        for (int i = 0; i < 8; i++) n += int'(p[i]);
        if (cfg_main == 2'd0) return |p;
        if (cfg_main == 2'd1) begin
            if (cfg_mask == '0) return 1'b0;
            for (int i = 0; i < 8; i++) if (cfg_mask[i] && !p[i]) return 1'b0;
            return 1'b1;
        end
        return n >= int'(cfg_maj_lvl);
    endfunction

    function automatic string tag_of();
        string s;
        case (cfg_main)
            2'd0: s = "R5";
            2'd1: s = "R6";
            default: s = "R7";
        endcase
        case (cfg_pair)
            2'd1: s = {s, "/R3"};
            2'd2: s = {s, "/R4"};
            default: s = {s, "/R2"};
        endcase
        if (cfg_mask != '1) s = {s, "/R1"};
        if (cfg_gate_w == '0) s = {s, "/R8"};
        else if (cfg_retrig) s = {s, "/R10"};
        else s = {s, "/R9"};
        if (cfg_invert) s = {s, "/R11"};
        return s;
    endfunction

    // One cycle: drive at negedge, model two-cycle decision latency plus
    // the gate register (R8), check just after the edge.
    task automatic step(input logic [7:0] v);
        bit hn;
        bit h;
        bit g;
        @(negedge clk);
        trig_in = v;
        hn = ref_hit(v);
        @(posedge clk);
        edge_n++;
        h = hm2;
        hm2 = hm1;
        hm1 = hn;
        if (cfg_gate_w == '0) begin
            g = h;
        end else begin
            if (h && (cfg_retrig || edge_n > close_e)) close_e = edge_n + int'(cfg_gate_w);
            g = edge_n < close_e;
        end
        #2;
        vectors++;
        if (trig_out !== (g ^ cfg_invert)) begin
            fails++;
            $display("FAIL %s edge %0d in=%h: trig_out=%b expected=%b",
                     tag_of(), edge_n, v, trig_out, g ^ cfg_invert);
        end
    endtask

    // Drain the pipeline quietly, then apply a new configuration.
    task automatic apply_cfg(input logic [1:0] pm, input logic [1:0] mm,
                             input logic [3:0] lvl, input logic [7:0] msk,
                             input logic [GW-1:0] w, input logic rt,
                             input logic inv);
        @(negedge clk);
        cfg_main = 2'd0;
        trig_in = '0;
        repeat (20) @(negedge clk);
        cfg_pair = pm; cfg_main = mm; cfg_maj_lvl = lvl; cfg_mask = msk;
        cfg_gate_w = w; cfg_retrig = rt; cfg_invert = inv;
        hm1 = ref_hit(8'h00);
        hm2 = hm1;
        close_e = -100;
    endtask

    initial begin
        logic [7:0] masks [3];
        logic [3:0] lvls [4];
        masks[0] = 8'hFF; masks[1] = 8'h5A; masks[2] = 8'h00;
        lvls[0] = 4'd0; lvls[1] = 4'd1; lvls[2] = 4'd4; lvls[3] = 4'd8;

        // R11: reset state follows the polarity setting.
        repeat (3) @(negedge clk);
        vectors++;
        if (trig_out !== 1'b1) begin
            fails++;
            $display("FAIL R11 reset inverted: trig_out=%b expected=1", trig_out);
        end
        cfg_invert = 1'b0;
        #1;
        vectors++;
        if (trig_out !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset direct: trig_out=%b expected=0", trig_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1..R8: exhaustive input sweep in linear mode.
        for (int pm = 0; pm < 4; pm++) begin
            for (int mi = 0; mi < 3; mi++) begin
                for (int mc = 0; mc < 7; mc++) begin
                    logic [1:0] mm;
                    logic [3:0] lv;
                    mm = (mc == 0) ? 2'd0 : (mc == 1) ? 2'd1 : (mc == 6) ? 2'd3 : 2'd2;
                    lv = (mc >= 2 && mc <= 5) ? lvls[mc-2] : 4'd9;
                    apply_cfg(2'(pm), mm, lv, masks[mi], '0, 1'b0, 1'(mi == 1 && pm == 1));
                    for (int v = 0; v < 256; v++) step(8'(v));
                end
            end
        end

        // R9 R10 R11: gate widths under sparse random decisions.
        for (int wi = 0; wi < 3; wi++) begin
            for (int rt = 0; rt < 2; rt++) begin
                for (int inv = 0; inv < 2; inv++) begin
                    logic [GW-1:0] w;
                    w = (wi == 0) ? GW'(1) : (wi == 1) ? GW'(3) : GW'(7);
                    apply_cfg(2'd0, 2'd0, 4'd0, 8'hFF, w, 1'(rt), 1'(inv));
                    for (int c = 0; c < 400; c++) begin
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        step((lfsr[2:0] == 3'd0) ? lfsr[12:5] : 8'h00);
                    end
                end
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: finished=0 expected=1");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule